// File: doc/BRIEF.md
# Descriptor-Chain DMA Sequencer

This block sequences buffer transfers between on-device memory and host memory. Software programs one list pointer for each direction and an enable mask, then writes a command code. The engine reads the descriptor chain for that direction through a simple word-read port. Each descriptor is three consecutive 32-bit words, and descriptors sit 12 bytes apart. The engine validates every descriptor and stages it in an internal bank. It then hands the staged descriptors, one burst request at a time, to an external data mover over a request/acknowledge handshake.

The "read" direction carries data from host memory into device memory. It stages a single descriptor. The "write" direction carries device data to the host and stages up to a fixed number of descriptor sets. A status register reports a busy bit for each direction, an error bit for each direction, and a linked-list error bit. The error bits stay set until software clears them by writing ones. One-cycle pulses report completion for each direction and any error.

Top module: `sgdma_ctrl`

## Requirements
- R1: After reset, the status register (offset 0x08) and the enable register (offset 0x04) read zero, and neither `fetch_req` nor `mv_req` is asserted.
- R2: A write to the command register (offset 0x00) is decoded as follows: value 1 starts the read chain, 2 starts the write chain, 4 is stop and 0 is cancel. Any other value has no effect.
- R3: A start command is ignored unless its enable bit is set. Enable bit 0 gates read and bit 1 gates write.
- R4: The engine fetches each descriptor from the list pointer as three words in this order: local address, host address, length. The list pointer for read is at offset 0x10 and the one for write at offset 0x14. The next descriptor follows 12 bytes later. Each burst presents the local address, the host address and length bits [30:0] as the byte count. `mv_to_host` is 1 for the write direction and 0 for read.
- R5: Bit 31 of the length word ends the chain. The engine fetches the whole chain before it issues any burst. After the last burst is acknowledged, busy clears and `rd_done` or `wr_done` pulses for exactly one cycle.
- R6: A write chain may hold up to 8 descriptors. If the 8th descriptor has no end flag, status bit 4 (linked-list error) is set, no burst is issued and busy clears.
- R7: A read chain holds one descriptor. If that descriptor has no end flag, status bit 4 is set and no burst is issued.
- R8: A length of zero, or a length whose bits [1:0] are not zero, sets the error bit of that direction (bit 2 for read, bit 3 for write). It also raises `err_pulse` once, and no burst is issued.
- R9: Status bit 0 is read busy and bit 1 is write busy, and at most one of them is set. Error bits stay set until a status write with a one in that bit position.
- R10: Cancel lets the outstanding fetch or burst handshake finish. The engine goes idle on the edge that completes it, with no done pulse. Cancel also clears the enable register and leaves the error bits unchanged.
- R11: Stop ends a chain in the same way as cancel but leaves the enable register unchanged.
- R12: A start command issued while either direction is busy is ignored.
- R13: `fetch_req` with its address, and `mv_req` with its burst fields, stay asserted and stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fetch_req | output | 1 | Descriptor word read request |
| fetch_addr | output | 32 | Host byte address of the descriptor word |
| fetch_ack | input | 1 | Fetch accepted, `fetch_data` valid |
| fetch_data | input | 32 | Descriptor word |
| mv_req | output | 1 | Burst request to the data mover |
| mv_to_host | output | 1 | 1: local to host (write), 0: host to local (read) |
| mv_local_addr | output | 32 | Local memory address of the burst |
| mv_host_addr | output | 32 | Host memory address of the burst |
| mv_bytes | output | 31 | Burst byte count |
| mv_ack | input | 1 | Burst completed |
| rd_done | output | 1 | One-cycle completion pulse, read chain |
| wr_done | output | 1 | One-cycle completion pulse, write chain |
| err_pulse | output | 1 | One-cycle pulse on any chain error |

## Verification
The assertions assume that the fetch and mover responders never raise an acknowledge unless the matching request is high. They also assume that software writes at most one command per cycle through the register port. The bench responders derive each acknowledge from the request seen on the previous edge, so an acknowledge never appears without a request. The bench issues every register access as a single-cycle strobe. To exercise mid-transfer commands, the mover is stalled, which keeps the request pending while cancel, stop or a second start arrive.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    localparam int DW = 32;
    localparam int LEN_W = DW - 1;

    // register byte offsets
    localparam int OFF_CTRL    = 'h00;
    localparam int OFF_ENABLE  = 'h04;
    localparam int OFF_STATUS  = 'h08;
    localparam int OFF_RD_LIST = 'h10;
    localparam int OFF_WR_LIST = 'h14;

    // command codes
    localparam logic [DW-1:0] CMD_CANCEL = 32'd0;
    localparam logic [DW-1:0] CMD_READ   = 32'd1;
    localparam logic [DW-1:0] CMD_WRITE  = 32'd2;
    localparam logic [DW-1:0] CMD_STOP   = 32'd4;

    typedef struct packed {
        logic [DW-1:0]    loc;
        logic [DW-1:0]    host;
        logic [LEN_W-1:0] len;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ISSUE = 2'd2
    } eng_st_e;

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [1:0]        busy,
    input  logic [2:0]        set_err,   // {ll, wr, rd}
    output logic              start_rd,
    output logic              start_wr,
    output logic              abort_cmd,
    output logic [1:0]        en,
    output logic [DW-1:0]     rd_ptr,
    output logic [DW-1:0]     wr_ptr
);

    typedef struct packed {
        logic [1:0]    en;
        logic [2:0]    err;
        logic [DW-1:0] rd_ptr;
        logic [DW-1:0] wr_ptr;
    } regs_t;

    regs_t q, d;

    logic hit_ctrl, hit_en, hit_st, hit_rdl, hit_wrl;

    always_comb begin
        hit_ctrl = reg_wr && (reg_addr == REG_AW'(OFF_CTRL));
        hit_en   = reg_wr && (reg_addr == REG_AW'(OFF_ENABLE));
        hit_st   = reg_wr && (reg_addr == REG_AW'(OFF_STATUS));
        hit_rdl  = reg_wr && (reg_addr == REG_AW'(OFF_RD_LIST));
        hit_wrl  = reg_wr && (reg_addr == REG_AW'(OFF_WR_LIST));

        start_rd  = hit_ctrl && (reg_wdata == CMD_READ);
        start_wr  = hit_ctrl && (reg_wdata == CMD_WRITE);
        abort_cmd = hit_ctrl && ((reg_wdata == CMD_CANCEL) || (reg_wdata == CMD_STOP));

        d = q;
        if (hit_en)  d.en = reg_wdata[1:0];
        if (hit_ctrl && (reg_wdata == CMD_CANCEL)) d.en = 2'b00;
        if (hit_rdl) d.rd_ptr = reg_wdata;
        if (hit_wrl) d.wr_ptr = reg_wdata;
        if (hit_st)  d.err = q.err & ~reg_wdata[4:2];
        d.err = d.err | set_err;

        case (reg_addr)
            REG_AW'(OFF_ENABLE):  reg_rdata = {30'd0, q.en};
            REG_AW'(OFF_STATUS):  reg_rdata = {27'd0, q.err, busy};
            REG_AW'(OFF_RD_LIST): reg_rdata = q.rd_ptr;
            REG_AW'(OFF_WR_LIST): reg_rdata = q.wr_ptr;
            default:              reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en     = q.en;
    assign rd_ptr = q.rd_ptr;
    assign wr_ptr = q.wr_ptr;

    // R9
    err_ll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err[2] && !(hit_st && reg_wdata[4])) |=> q.err[2]);
    // R9
    err_rd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err[0] && !(hit_st && reg_wdata[2])) |=> q.err[0]);
    // R11
    stop_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ctrl && reg_wdata == CMD_STOP) |=> $stable(q.en));

endmodule

// File: rtl/sgdma_desc_bank.sv
module sgdma_desc_bank
    import sgdma_pkg::*;
#(
    parameter int NSETS  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] widx,
    input  desc_t             wdata,
    input  logic [SLOT_W-1:0] ridx,
    output desc_t             rdata
);

    desc_t slot_q [NSETS];

    for (genvar i = 0; i < NSETS; i++) begin : g_slot
        desc_t slot_d;
        always_comb begin
            slot_d = slot_q[i];
            if (we && (widx == SLOT_W'(i))) slot_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSETS; i++)
            if (ridx == SLOT_W'(i)) rdata = slot_q[i];
    end

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int WR_SETS = 8,
    parameter int RD_SETS = 1,
    parameter int SLOT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              abort_cmd,
    input  logic [1:0]        en,
    input  logic [DW-1:0]     rd_ptr,
    input  logic [DW-1:0]     wr_ptr,
    output logic              fetch_req,
    output logic [DW-1:0]     fetch_addr,
    input  logic              fetch_ack,
    input  logic [DW-1:0]     fetch_data,
    output logic              bk_we,
    output logic [SLOT_W-1:0] bk_widx,
    output desc_t             bk_wdata,
    output logic [SLOT_W-1:0] bk_ridx,
    output logic              mv_req,
    output logic              mv_dir,
    input  logic              mv_ack,
    output logic [1:0]        busy,
    output logic              done_rd,
    output logic              done_wr,
    output logic [2:0]        err_set    // {ll, wr, rd}
);

    localparam logic [SLOT_W-1:0] WR_LAST = SLOT_W'(WR_SETS - 1);
    localparam logic [SLOT_W-1:0] RD_LAST = SLOT_W'(RD_SETS - 1);

    typedef struct packed {
        eng_st_e           st;
        logic              dir;      // 1 = write (to host)
        logic [DW-1:0]     ptr;
        logic [1:0]        word;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] last_slot;
        logic [DW-1:0]     loc;
        logic [DW-1:0]     host;
        logic              abort;
        logic              done_rd;
        logic              done_wr;
        logic [2:0]        err;
    } eng_t;

    eng_t q, d;
    logic [SLOT_W-1:0] cap_last;
    logic              len_bad;

    always_comb begin
        d = q;
        d.done_rd = 1'b0;
        d.done_wr = 1'b0;
        d.err     = 3'b000;
        fetch_req = 1'b0;
        mv_req    = 1'b0;
        bk_we     = 1'b0;
        bk_wdata  = '0;
        cap_last  = q.dir ? WR_LAST : RD_LAST;
        len_bad   = (fetch_data[LEN_W-1:0] == '0) || (fetch_data[1:0] != 2'b00);

        case (q.st)
            ST_IDLE: begin
                d.abort = 1'b0;
                if (start_rd && en[0]) begin
                    d.st = ST_FETCH; d.dir = 1'b0; d.ptr = rd_ptr;
                    d.word = 2'd0;   d.slot = '0;
                end else if (start_wr && en[1]) begin
                    d.st = ST_FETCH; d.dir = 1'b1; d.ptr = wr_ptr;
                    d.word = 2'd0;   d.slot = '0;
                end
            end
            ST_FETCH: begin
                fetch_req = 1'b1;
                if (abort_cmd) d.abort = 1'b1;
                if (fetch_ack) begin
                    d.ptr  = q.ptr + 32'd4;
                    d.word = q.word + 2'd1;
                    if (q.abort || abort_cmd) begin
                        d.st = ST_IDLE;
                    end else if (q.word == 2'd0) begin
                        d.loc = fetch_data;
                    end else if (q.word == 2'd1) begin
                        d.host = fetch_data;
                    end else begin
                        d.word = 2'd0;
                        if (len_bad) begin
                            d.st = ST_IDLE;
                            if (q.dir) d.err[1] = 1'b1;
                            else       d.err[0] = 1'b1;
                        end else begin
                            bk_we    = 1'b1;
                            bk_wdata = '{loc: q.loc, host: q.host, len: fetch_data[LEN_W-1:0]};
                            if (fetch_data[DW-1]) begin
                                d.last_slot = q.slot;
                                d.slot      = '0;
                                d.st        = ST_ISSUE;
                            end else if (q.slot == cap_last) begin
                                d.err[2] = 1'b1;
                                d.st     = ST_IDLE;
                            end else begin
                                d.slot = q.slot + 1'b1;
                            end
                        end
                    end
                end
            end
            ST_ISSUE: begin
                mv_req = 1'b1;
                if (abort_cmd) d.abort = 1'b1;
                if (mv_ack) begin
                    if (q.abort || abort_cmd) begin
                        d.st = ST_IDLE;
                    end else if (q.slot == q.last_slot) begin
                        d.st = ST_IDLE;
                        if (q.dir) d.done_wr = 1'b1;
                        else       d.done_rd = 1'b1;
                    end else begin
                        d.slot = q.slot + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign fetch_addr = q.ptr;
    assign bk_widx    = q.slot;
    assign bk_ridx    = q.slot;
    assign mv_dir     = q.dir;
    assign busy       = {q.st != ST_IDLE && q.dir, q.st != ST_IDLE && !q.dir};
    assign done_rd    = q.done_rd;
    assign done_wr    = q.done_wr;
    assign err_set    = q.err;

    // R13
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));
    // R13
    mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_ack) |=> (mv_req && $stable(bk_ridx) && $stable(mv_dir)));
    // R9
    busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd || done_wr) |-> (busy == 2'b00));
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd || done_wr) |=> !(done_rd || done_wr));
    // R12
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy != 2'b00 && !(mv_req && mv_ack) && !(fetch_req && fetch_ack)) |=> $stable(mv_dir));

endmodule

// File: rtl/sgdma_ctrl.sv
module sgdma_ctrl
    import sgdma_pkg::*;
#(
    parameter int REG_AW  = 8,
    parameter int WR_SETS = 8,
    parameter int RD_SETS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              fetch_req,
    output logic [31:0]       fetch_addr,
    input  logic              fetch_ack,
    input  logic [31:0]       fetch_data,
    output logic              mv_req,
    output logic              mv_to_host,
    output logic [31:0]       mv_local_addr,
    output logic [31:0]       mv_host_addr,
    output logic [30:0]       mv_bytes,
    input  logic              mv_ack,
    output logic              rd_done,
    output logic              wr_done,
    output logic              err_pulse
);

    localparam int NSETS  = (WR_SETS > RD_SETS) ? WR_SETS : RD_SETS;
    localparam int SLOT_W = (NSETS > 1) ? $clog2(NSETS) : 1;

    logic              start_rd, start_wr, abort_cmd;
    logic [1:0]        en, busy;
    logic [DW-1:0]     rd_ptr, wr_ptr;
    logic [2:0]        err_set;
    logic              bk_we;
    logic [SLOT_W-1:0] bk_widx, bk_ridx;
    desc_t             bk_wdata, bk_rdata;

    sgdma_regs #(.REG_AW(REG_AW)) u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .busy, .set_err(err_set), .start_rd, .start_wr, .abort_cmd,
        .en, .rd_ptr, .wr_ptr
    );

    sgdma_engine #(.WR_SETS(WR_SETS), .RD_SETS(RD_SETS), .SLOT_W(SLOT_W)) u_eng (
        .clk, .rst_n, .start_rd, .start_wr, .abort_cmd, .en, .rd_ptr, .wr_ptr,
        .fetch_req, .fetch_addr, .fetch_ack, .fetch_data,
        .bk_we, .bk_widx, .bk_wdata, .bk_ridx,
        .mv_req, .mv_dir(mv_to_host), .mv_ack,
        .busy, .done_rd(rd_done), .done_wr(wr_done), .err_set
    );

    sgdma_desc_bank #(.NSETS(NSETS), .SLOT_W(SLOT_W)) u_bank (
        .clk, .rst_n, .we(bk_we), .widx(bk_widx), .wdata(bk_wdata),
        .ridx(bk_ridx), .rdata(bk_rdata)
    );

    assign mv_local_addr = bk_rdata.loc;
    assign mv_host_addr  = bk_rdata.host;
    assign mv_bytes      = bk_rdata.len;
    assign err_pulse     = |err_set;

    // R10
    mv_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> (busy != 2'b00));
    // R5
    fetch_before_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> !fetch_req);

endmodule

// File: tb/sgdma_ctrl_tb.sv
module sgdma_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic [31:0] fetch_data = '0;
    logic        mv_req, mv_to_host;
    logic [31:0] mv_local_addr, mv_host_addr;
    logic [30:0] mv_bytes;
    logic        mv_ack = 1'b0;
    logic        rd_done, wr_done, err_pulse;

    always #2 clk = ~clk;

    sgdma_ctrl u_dut (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .fetch_req, .fetch_addr, .fetch_ack, .fetch_data,
        .mv_req, .mv_to_host, .mv_local_addr, .mv_host_addr, .mv_bytes, .mv_ack,
        .rd_done, .wr_done, .err_pulse
    );

    logic [31:0] mem [64];
    logic        mv_stall = 1'b0;
    int          n_chk = 0, n_fail = 0;

    // bench responders and event logs
    int          log_n = 0, n_rd_done = 0, n_wr_done = 0, n_err = 0, n_fetch = 0;
    logic [31:0] lg_loc [32];
    logic [31:0] lg_host [32];
    logic [30:0] lg_len [32];
    logic        lg_dir [32];

    always @(posedge clk) begin
        fetch_ack  <= fetch_req && !fetch_ack;
        fetch_data <= mem[fetch_addr[7:2]];
        mv_ack     <= mv_req && !mv_ack && !mv_stall;
        if (fetch_req && fetch_ack) n_fetch <= n_fetch + 1;
        if (mv_req && mv_ack && log_n < 32) begin
            lg_loc[log_n]  <= mv_local_addr;
            lg_host[log_n] <= mv_host_addr;
            lg_len[log_n]  <= mv_bytes;
            lg_dir[log_n]  <= mv_to_host;
            log_n <= log_n + 1;
        end
        if (rd_done)   n_rd_done <= n_rd_done + 1;
        if (wr_done)   n_wr_done <= n_wr_done + 1;
        if (err_pulse) n_err <= n_err + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd_reg(8'h08, s);
            if (s[1:0] == 2'b00) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic put_desc(input int w, input logic [31:0] l, input logic [31:0] h,
                            input logic [31:0] n);
        mem[w] = l; mem[w+1] = h; mem[w+2] = n;
    endtask

    task automatic clear_status();
        wr_reg(8'h08, 32'h1C);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(8'h08, v); check("R1 status", v, 0);
        rd_reg(8'h04, v); check("R1 enable", v, 0);
        check("R1 fetch_req", {31'd0, fetch_req}, 0);
        check("R1 mv_req", {31'd0, mv_req}, 0);
    endtask

    task automatic t_write_chain();
        int b = log_n, dw = n_wr_done;
        logic [31:0] v;
        put_desc(0, 32'h1000, 32'h8000_0000, 32'd64);
        put_desc(3, 32'h2000, 32'h8000_1000, 32'd128);
        put_desc(6, 32'h3000, 32'h8000_2000, 32'h8000_0020);
        wr_reg(8'h14, 32'h0);
        wr_reg(8'h04, 32'h2);
        wr_reg(8'h00, 32'h2);
        rd_reg(8'h08, v); check("R9 write busy bit1", v & 3, 2);
        wait_idle();
        check("R5 three bursts", log_n - b, 3);
        check("R4 burst0 local", lg_loc[b], 32'h1000);
        check("R4 burst1 host", lg_host[b+1], 32'h8000_1000);
        check("R4 burst2 bytes", {1'b0, lg_len[b+2]}, 32);
        check("R4 to_host", {31'd0, lg_dir[b]}, 1);
        check("R5 one wr_done", n_wr_done - dw, 1);
        rd_reg(8'h08, v); check("R5 busy clear", v, 0);
    endtask

    task automatic t_read_single();
        int b = log_n, dr = n_rd_done;
        put_desc(20, 32'h4000, 32'h9000_0000, 32'h8000_0100);
        wr_reg(8'h10, 32'd80);
        wr_reg(8'h04, 32'h1);
        wr_reg(8'h00, 32'h1);
        wait_idle();
        check("R4 read burst count", log_n - b, 1);
        check("R4 read dir", {31'd0, lg_dir[b]}, 0);
        check("R4 read bytes", {1'b0, lg_len[b]}, 32'h100);
        check("R5 one rd_done", n_rd_done - dr, 1);
    endtask

    task automatic t_enable_gate();
        int f = n_fetch;
        logic [31:0] v;
        wr_reg(8'h04, 32'h1);
        wr_reg(8'h00, 32'h2);
        repeat (6) @(negedge clk);
        rd_reg(8'h08, v); check("R3 write blocked by enable", v, 0);
        check("R3 no fetch", n_fetch - f, 0);
        wr_reg(8'h04, 32'h3);
        wr_reg(8'h00, 32'h3);
        repeat (6) @(negedge clk);
        rd_reg(8'h08, v); check("R2 unknown code ignored", v, 0);
        check("R2 no fetch on code 3", n_fetch - f, 0);
    endtask

    task automatic t_len_errors();
        int b = log_n, e = n_err;
        logic [31:0] v;
        put_desc(24, 32'h5000, 32'h1, 32'h8000_0000);
        wr_reg(8'h14, 32'd96);
        wr_reg(8'h00, 32'h2);
        wait_idle();
        rd_reg(8'h08, v); check("R8 zero length wr error bit3", v, 32'h8);
        check("R8 err pulse", n_err - e, 1);
        check("R8 no burst", log_n - b, 0);
        clear_status();
        put_desc(27, 32'h5000, 32'h1, 32'h8000_0006);
        wr_reg(8'h10, 32'd108);
        wr_reg(8'h00, 32'h1);
        wait_idle();
        rd_reg(8'h08, v); check("R8 unaligned rd error bit2", v, 32'h4);
        wr_reg(8'h08, 32'h8);
        rd_reg(8'h08, v); check("R9 writing other bit keeps error", v, 32'h4);
        wr_reg(8'h08, 32'h4);
        rd_reg(8'h08, v); check("R9 write-one clears", v, 0);
    endtask

    task automatic t_write_cap();
        int b = log_n, dw = n_wr_done;
        logic [31:0] v;
        for (int i = 0; i < 8; i++)
            put_desc(16 + 3*i, 32'h100 * i, 32'hA000_0000 + i, (i == 7) ? 32'h8000_0010 : 32'd16);
        wr_reg(8'h14, 32'd64);
        wr_reg(8'h00, 32'h2);
        wait_idle();
        check("R6 eight bursts", log_n - b, 8);
        check("R6 last local", lg_loc[b+7], 32'h700);
        check("R6 done", n_wr_done - dw, 1);
        b = log_n;
        mem[16 + 21 + 2] = 32'd16;
        wr_reg(8'h00, 32'h2);
        wait_idle();
        rd_reg(8'h08, v); check("R6 overflow ll error", v, 32'h10);
        check("R6 no bursts on overflow", log_n - b, 0);
        clear_status();
    endtask

    task automatic t_read_nolast();
        int b = log_n;
        logic [31:0] v;
        put_desc(20, 32'h4000, 32'h9000_0000, 32'h100);
        wr_reg(8'h10, 32'd80);
        wr_reg(8'h00, 32'h1);
        wait_idle();
        rd_reg(8'h08, v); check("R7 read chain ll error", v, 32'h10);
        check("R7 no burst", log_n - b, 0);
    endtask

    task automatic t_abort(input logic [31:0] code, input string rq, input logic [31:0] exp_en);
        int b = log_n, dw = n_wr_done;
        logic [31:0] v;
        wr_reg(8'h04, 32'h3);
        wr_reg(8'h14, 32'h0);
        mv_stall = 1'b1;
        wr_reg(8'h00, 32'h2);
        for (int i = 0; i < 200 && !mv_req; i++) @(negedge clk);
        wr_reg(8'h00, code);
        repeat (3) @(negedge clk);
        rd_reg(8'h08, v); check({rq, " busy held during handshake"}, v, 32'h12);
        mv_stall = 1'b0;
        wait_idle();
        check({rq, " only in-flight burst"}, log_n - b, 1);
        check({rq, " no done"}, n_wr_done - dw, 0);
        rd_reg(8'h04, v); check({rq, " enable"}, v, exp_en);
        rd_reg(8'h08, v); check({rq, " error kept"}, v, 32'h10);
    endtask

    task automatic t_busy_start();
        int b = log_n, dw = n_wr_done, dr = n_rd_done;
        wr_reg(8'h04, 32'h3);
        mv_stall = 1'b1;
        wr_reg(8'h00, 32'h2);
        for (int i = 0; i < 200 && !mv_req; i++) @(negedge clk);
        wr_reg(8'h00, 32'h1);
        mv_stall = 1'b0;
        wait_idle();
        check("R12 write bursts only", log_n - b, 3);
        check("R12 last burst dir", {31'd0, lg_dir[b+2]}, 1);
        check("R12 no rd_done", n_rd_done - dr, 0);
        check("R12 wr_done", n_wr_done - dw, 1);
    endtask

    initial begin
        bit wd = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_write_chain();
                t_read_single();
                t_enable_gate();
                t_len_errors();
                t_write_cap();
                t_read_nolast();
                t_abort(32'h0, "R10 cancel", 32'h0);
                t_abort(32'h4, "R11 stop", 32'h3);
                clear_status();
                t_busy_start();
            end
            begin
                repeat (100000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule